// File: doc/BRIEF.md
# Stereo Digital Attenuator with Ramped Gain and Soft Mute

This block is a per-sample gain stage for a stereo stream of 16-bit two's complement samples. Each sample pair that arrives with a valid strobe is multiplied by a gain taken from a 7-bit code N, for a level of 20·log10(N/128) dB. Code 0x7F is treated as exactly unity, code 0x01 is about −42 dB and code 0x00 silences the output. The left and right samples share one gain code.

The gain never jumps. A control word loads a target code, and the current code then moves one step toward that target for every eight sample strobes. A full fall from unity to silence therefore lasts close to a thousand sample periods. A new target that arrives during a ramp turns the ramp toward the new value from wherever the level is at that moment. A level-sensitive mute input overrides the target with zero while it is high, so the gain fades out. When mute is released, the gain fades back to the stored target.

Top module: `audio_gain_ramp`

## Requirements
- R1: On a clock with `smp_valid` high, each output becomes (input × M) >>> 7 one cycle later. M is the current code, except that code 0x7F uses M = 128. The code used is the `gain_code` value present on that strobe. Outputs hold between strobes.
- R2: While `gain_code` is 0, every strobed output is 0 for any input.
- R3: A `tgt_load` pulse with `tgt_code[7]` = 0 stores `tgt_code[6:0]` as the target. A pulse with `tgt_code[7]` = 1 is ignored, and the previous target is kept.
- R4: While `gain_code` differs from the effective target, it moves by exactly one toward the target on every 8th strobe. It stays put when it equals the target, and it changes only on strobe cycles. The strobe count restarts from zero whenever the code sits at the target on a strobe.
- R5: With mute held from a settled code of 0x7F, `gain_code` reaches 0 on exactly the 1016th strobe (127 steps of 8).
- R6: A new target loaded during a ramp does not restart the strobe count. The next step lands where the running count completes 8 strobes, and it moves toward the new target.
- R7: While `mute_req` is high, the effective target is 0 and `gain_code` never rises. After release, the code ramps back to the stored target.
- R8: Synchronous reset sets the target to 0x7F and clears `gain_code` and both outputs to 0. The code then ramps up to 0x7F, which takes 1016 strobes.
- R9: Both channels are scaled by the same code on the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 16 | Left input sample, two's complement |
| smp_right | input | 16 | Right input sample, two's complement |
| tgt_load | input | 1 | Target load strobe |
| tgt_code | input | 8 | Bit 7 = ignore flag, bits 6:0 = target code |
| mute_req | input | 1 | Mute request, level sensitive |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| gain_code | output | 7 | Current gain code |

## Verification
The hidden state here is the stored target and the eight-strobe step counter. A wrong target shows up within eight strobes as a step in the wrong direction, or as a missing step, on `gain_code`. A counter that is off by one or that restarts wrongly moves the step to the wrong strobe, and this is caught on the first step after a load, a mute or a retarget. A fault in the multiplier shows on the outputs on the very next sample at any code below 0x7F. A faulty unity special case shows at full-scale inputs.

// File: rtl/audio_gain_pkg.sv
package audio_gain_pkg;
   typedef enum logic [1:0] {
      RAMP_HOLD = 2'd0,
      RAMP_DOWN = 2'd1,
      RAMP_UP   = 2'd2
   } ramp_dir_e;

   function automatic ramp_dir_e ramp_dir(input int unsigned cur, input int unsigned goal);
      if (cur == goal)     return RAMP_HOLD;
      else if (cur > goal) return RAMP_DOWN;
      else                 return RAMP_UP;
   endfunction
endpackage

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
   import audio_gain_pkg::*;
#(
   parameter int CODE_W   = 7,
   parameter int STEP_DIV = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_valid,
   input  logic              tgt_load,
   input  logic [CODE_W:0]   tgt_code,
   input  logic              mute_req,
   output logic [CODE_W-1:0] cur_code
);
   localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

   logic [CODE_W-1:0] tgt_q;
   logic [CODE_W-1:0] goal;
   logic              step_now;
   ramp_dir_e         dir;

   // target register; a set ignore flag leaves it untouched
   always_ff @(posedge clk) begin
      if (rst)
         tgt_q <= CODE_MAX;
      else if (tgt_load && !tgt_code[CODE_W])
         tgt_q <= tgt_code[CODE_W-1:0];
   end

   assign goal = mute_req ? '0 : tgt_q;

   always_comb begin
      dir = ramp_dir(int'(cur_code), int'(goal));
   end

   generate
      if (STEP_DIV > 1) begin : g_divider
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk) begin
            if (rst)
               div_q <= '0;
            else if (smp_valid) begin
               if (dir == RAMP_HOLD || div_q == DIV_LAST)
                  div_q <= '0;
               else
                  div_q <= div_q + DIV_W'(1);
            end
         end
         assign step_now = smp_valid && (dir != RAMP_HOLD) && (div_q == DIV_LAST);
      end else begin : g_no_divider
         assign step_now = smp_valid && (dir != RAMP_HOLD);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         cur_code <= '0;
      else if (step_now) begin
         case (dir)
            RAMP_DOWN: cur_code <= cur_code - CODE_ONE;
            RAMP_UP:   cur_code <= cur_code + CODE_ONE;
            default:   cur_code <= cur_code;
         endcase
      end
   end
endmodule

// File: rtl/gain_scale_chan.sv
module gain_scale_chan #(
   parameter int SAMPLE_W = 16,
   parameter int CODE_W   = 7
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_in,
   input  logic        [CODE_W-1:0]   code,
   output logic signed [SAMPLE_W-1:0] smp_out
);
   localparam int MULT_W = CODE_W + 2;
   localparam int PROD_W = SAMPLE_W + MULT_W;
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   logic signed [MULT_W-1:0] mult;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;

   // full-scale code maps to an exact power of two so unity is lossless
   always_comb begin
      if (code == CODE_MAX)
         mult = MULT_W'(1) <<< CODE_W;
      else
         mult = signed'({2'b00, code});
      prod    = PROD_W'(smp_in) * PROD_W'(mult);
      shifted = prod >>> CODE_W;
   end

   always_ff @(posedge clk) begin
      if (rst)
         smp_out <= '0;
      else if (smp_valid)
         smp_out <= shifted[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/audio_gain_ramp.sv
module audio_gain_ramp #(
   parameter int SAMPLE_W = 16,
   parameter int CODE_W   = 7,
   parameter int STEP_DIV = 8,
   parameter int N_CHAN   = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                tgt_load,
   input  logic [CODE_W:0]     tgt_code,
   input  logic                mute_req,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right,
   output logic [CODE_W-1:0]   gain_code
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_sample_w
         $error("SAMPLE_W must be at least 2");
      end
      if (CODE_W < 2) begin : g_bad_code_w
         $error("CODE_W must be at least 2");
      end
      if (STEP_DIV < 1) begin : g_bad_step_div
         $error("STEP_DIV must be at least 1");
      end
      if (N_CHAN != 2) begin : g_bad_chan
         $error("N_CHAN must be 2 for the stereo port set");
      end
   endgenerate

   logic [N_CHAN-1:0][SAMPLE_W-1:0] chan_in;
   logic [N_CHAN-1:0][SAMPLE_W-1:0] chan_out;

   assign chan_in[0] = smp_left;
   assign chan_in[1] = smp_right;

   gain_ramp_ctrl #(
      .CODE_W  (CODE_W),
      .STEP_DIV(STEP_DIV)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .smp_valid(smp_valid),
      .tgt_load (tgt_load),
      .tgt_code (tgt_code),
      .mute_req (mute_req),
      .cur_code (gain_code)
   );

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      logic signed [SAMPLE_W-1:0] s_out;
      gain_scale_chan #(
         .SAMPLE_W(SAMPLE_W),
         .CODE_W  (CODE_W)
      ) u_scale (
         .clk      (clk),
         .rst      (rst),
         .smp_valid(smp_valid),
         .smp_in   (signed'(chan_in[c])),
         .code     (gain_code),
         .smp_out  (s_out)
      );
      assign chan_out[c] = s_out;
   end

   assign out_left  = chan_out[0];
   assign out_right = chan_out[1];
endmodule

// File: rtl/audio_gain_ramp_chk.sv
module audio_gain_ramp_chk #(
   parameter int SAMPLE_W = 16,
   parameter int CODE_W   = 7
) (
   input logic                clk,
   input logic                rst,
   input logic                smp_valid,
   input logic [SAMPLE_W-1:0] smp_left,
   input logic [SAMPLE_W-1:0] smp_right,
   input logic                mute_req,
   input logic [SAMPLE_W-1:0] out_left,
   input logic [SAMPLE_W-1:0] out_right,
   input logic [CODE_W-1:0]   gain_code
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (gain_code == '0 && out_left == '0 && out_right == '0));

   assert_step_size_R4: assert property (@(posedge clk) disable iff (rst)
      (gain_code != $past(gain_code)) |->
         (gain_code == $past(gain_code) + CODE_W'(1) || gain_code == $past(gain_code) - CODE_W'(1)));

   assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !smp_valid |=> $stable(gain_code));

   assert_out_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !smp_valid |=> ($stable(out_left) && $stable(out_right)));

   assert_zero_gain_R2: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && gain_code == '0) |=> (out_left == '0 && out_right == '0));

   assert_unity_both_R9: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && gain_code == CODE_MAX) |=>
         (out_left == $past(smp_left) && out_right == $past(smp_right)));

   assert_mute_no_rise_R7: assert property (@(posedge clk) disable iff (rst)
      (mute_req && smp_valid) |=> (gain_code <= $past(gain_code)));
endmodule

bind audio_gain_ramp audio_gain_ramp_chk #(
   .SAMPLE_W(SAMPLE_W),
   .CODE_W  (CODE_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .smp_valid(smp_valid),
   .smp_left (smp_left),
   .smp_right(smp_right),
   .mute_req (mute_req),
   .out_left (out_left),
   .out_right(out_right),
   .gain_code(gain_code)
);

// File: tb/test_audio_gain_ramp.sv
`timescale 1ns/1ps
module test_audio_gain_ramp;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_left = '0;
   logic [15:0] smp_right = '0;
   logic        tgt_load = 1'b0;
   logic [7:0]  tgt_code = '0;
   logic        mute_req = 1'b0;
   logic [15:0] out_left;
   logic [15:0] out_right;
   logic [6:0]  gain_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_tgt = 127;
   int m_cur = 0;
   int m_div = 0;

   always #10 clk = ~clk;

   audio_gain_ramp i_audio_gain_ramp (
      .clk(clk), .rst(rst), .smp_valid(smp_valid),
      .smp_left(smp_left), .smp_right(smp_right),
      .tgt_load(tgt_load), .tgt_code(tgt_code), .mute_req(mute_req),
      .out_left(out_left), .out_right(out_right), .gain_code(gain_code)
   );

   function automatic int exp_scale(int s, int code);
      int m;
      int p;
      m = (code == 127) ? 128 : code;
      p = s * m;
      return p >>> 7;
   endfunction

   task automatic check_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // one strobe; compares both outputs and the code against the model
   task automatic strobe(int l, int r);
      int goal;
      int e_l;
      int e_r;
      @(negedge clk);
      smp_valid = 1'b1;
      smp_left  = 16'(l);
      smp_right = 16'(r);
      goal = mute_req ? 0 : m_tgt;
      e_l = exp_scale(l, m_cur);
      e_r = exp_scale(r, m_cur);
      if (m_cur == goal) m_div = 0;
      else if (m_div == 7) begin
         m_div = 0;
         m_cur = (m_cur > goal) ? m_cur - 1 : m_cur + 1;
      end else m_div++;
      @(negedge clk);
      smp_valid = 1'b0;
      check_eq("R1 left",  int'($signed(out_left)),  e_l);
      check_eq("R9 right", int'($signed(out_right)), e_r);
      check_eq("R4 code",  int'(gain_code), m_cur);
   endtask

   task automatic load(int word);
      @(negedge clk);
      tgt_load = 1'b1;
      tgt_code = 8'(word);
      @(negedge clk);
      tgt_load = 1'b0;
      if (word[7] == 1'b0) m_tgt = word & 127;
   endtask

   function automatic int rnd16();
      return int'($signed(16'($urandom())));
   endfunction

   initial begin
      int seed_dummy;
      int cnt;
      seed_dummy = $urandom(32'd1234);
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R8: reset state
      check_eq("R8 code", int'(gain_code), 0);
      check_eq("R8 left", int'(out_left), 0);
      check_eq("R8 right", int'(out_right), 0);

      // R4: first step on the 8th strobe
      repeat (7) strobe(rnd16(), rnd16());
      check_eq("R4 before step", int'(gain_code), 0);
      strobe(1000, -1000);
      check_eq("R4 step at 8", int'(gain_code), 1);

      // R8: ramp up to 0x7F in 1016 strobes
      repeat (1008) strobe(rnd16(), rnd16());
      check_eq("R8 ramp up", int'(gain_code), 127);

      // R1: unity at full scale
      strobe(-32768, 32767);
      strobe(-1, 1);

      // R3: ignored load keeps target
      load(8'h90);
      repeat (16) strobe(rnd16(), rnd16());
      check_eq("R3 ignored", int'(gain_code), 127);

      // R3: accepted load ramps down
      load(8'h60);
      repeat (80) strobe(rnd16(), rnd16());
      check_eq("R3 accepted", int'(gain_code), 117);

      // R6: retarget mid-count, step keeps its phase
      repeat (3) strobe(rnd16(), rnd16());
      load(8'h7F);
      repeat (4) strobe(rnd16(), rnd16());
      check_eq("R6 before step", int'(gain_code), 117);
      strobe(rnd16(), rnd16());
      check_eq("R6 retarget", int'(gain_code), 118);

      repeat (100) strobe(rnd16(), rnd16());
      check_eq("R7 settled", int'(gain_code), 127);

      // R5: full mute length
      mute_req = 1'b1;
      cnt = 0;
      while (gain_code != 0 && cnt < 1200) begin
         strobe(rnd16(), rnd16());
         cnt++;
      end
      check_eq("R5 mute strobes", cnt, 1016);

      // R2: zero code silences
      strobe(-32768, 32767);
      strobe(rnd16(), rnd16());

      // R7: release ramps back
      mute_req = 1'b0;
      repeat (8) strobe(rnd16(), rnd16());
      check_eq("R7 release", int'(gain_code), 1);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int pick;
         pick = int'($urandom_range(0, 99));
         if (pick < 3) load(int'($urandom_range(0, 255)));
         else if (pick < 5) begin
            @(negedge clk);
            mute_req = ~mute_req;
         end
         strobe(rnd16(), rnd16());
      end
      done = 1;
      report();
   end

   initial begin
      #(20ns * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         report();
      end
   end
endmodule